// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

A synthesizable behavioural model of a single-port synchronous static RAM. Every address, data and control pin is captured on the rising clock edge. Read data comes straight out of the array in the cycle after the command is registered. There is no extra output register.

A burst of four words is opened by either of two start strobes. The processor-side strobe always performs a read. The controller-side strobe reads or writes, as the write pins decide. After the first word, an internal two-bit counter supplies the remaining addresses. An advance pin steps this counter, and the counter wraps inside the aligned four-word group. The order is chosen by a pin sampled when the burst opens: either linear (add one to the low two address bits) or interleaved (XOR the count into the low two address bits).

Writes are controlled in two ways. A global write pin writes every byte lane. Otherwise, a lane-write enable together with per-lane selects writes only the chosen lanes. Three chip-enable pins qualify every strobe. A strobe that arrives while any chip enable is inactive deselects the device in that one cycle.

Top module: `sync_burst_sram`

## Requirements
- R1: While the synchronised reset is active, and afterwards until the first enabled strobe, `rdata_oe` is 0 and `rdata` is all zeros.
- R2: A read command registered at rising edge k shows `rdata_oe` = 1 and the addressed word on `rdata` before edge k+1. A write registered at edge k is committed at edge k+1, so a read registered at edge k+1 or later returns the new data.
- R3: With `order_sel` = 0 sampled at the burst start, each advance (`adv_n` = 0, both strobes high) adds 1 modulo 4 to address bits [1:0]. The upper address bits stay fixed.
- R4: With `order_sel` = 1 sampled at the burst start, the n-th word of the burst (n = 0..3) has address bits [1:0] equal to the start bits [1:0] XOR n. The upper address bits stay fixed.
- R5: With both strobes high and `adv_n` = 1, the current burst address is held, and the same word is read or written again.
- R6: An enabled cycle with `strb_proc_n` = 0 is always a read, whatever the write pins say. When both strobes are low, the processor strobe wins.
- R7: `all_wr_n` = 0 in a selected cycle without the processor strobe writes every lane, whatever `lane_wr_en_n` and `lane_sel_n` say.
- R8: With `all_wr_n` = 1 and `lane_wr_en_n` = 0, exactly the lanes i with `lane_sel_n[i]` = 0 are written. Lane i is bits [i*LANE_W +: LANE_W]. If no lane is selected, or `lane_wr_en_n` = 1, the cycle is a read.
- R9: The chip is enabled when `ce_a_n` = 0, `ce_b` = 1 and `ce_c_n` = 0 on a strobe cycle. A strobe without enable makes `rdata_oe` 0 from the next edge on. It loads no address. Advances and writes are then ignored until an enabled strobe.
- R10: `rdata_oe` is 0 in write cycles. Whenever `rdata_oe` is 0, `rdata` is all zeros.
- R11: After three advances the counter wraps, and a fourth advance returns to the starting word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_in | input | ADDR_W | Word address loaded by a start strobe |
| strb_proc_n | input | 1 | Processor-side burst start, active low, read only |
| strb_ctrl_n | input | 1 | Controller-side burst start, active low |
| adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_oe | output | 1 | Read data valid / output enable |

## Verification
The bench builds the block with ADDR_W = 6, LANES = 2 and LANE_W = 9, which gives 64 words of 18 bits. This is small enough to preload every word with distinct random data through sixteen aligned bursts, so any wrong burst address shows up as a data mismatch. Two lanes make a partial write distinguishable from a full write in both directions. Random strobes, advances, deselects and order changes then run against a bench model of the burst counter and array.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  // width of the in-burst word counter (four words per burst)
  localparam int BURST_W = 2;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } burst_order_e;

  // low address bits of the current burst word
  function automatic logic [BURST_W-1:0] burst_offset(
    input logic [BURST_W-1:0] start_lo,
    input logic [BURST_W-1:0] cnt,
    input burst_order_e       ord
  );
    logic [BURST_W-1:0] res;
    if (ord == ORDER_XOR) res = start_lo ^ cnt;
    else                  res = start_lo + cnt;
    return res;
  endfunction

endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode #(
  parameter int LANES = 2
) (
  input  logic             strb_proc_n,
  input  logic             strb_ctrl_n,
  input  logic             adv_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             ce_a_n,
  input  logic             ce_b,
  input  logic             ce_c_n,
  output logic             chip_en,
  output logic             any_strobe,
  output logic             step,
  output logic [LANES-1:0] wr_mask
);

  logic proc_strobe;

  always_comb begin
    chip_en     = ~ce_a_n & ce_b & ~ce_c_n;
    proc_strobe = ~strb_proc_n;
    any_strobe  = ~strb_proc_n | ~strb_ctrl_n;
    step        = ~any_strobe & ~adv_n;
  end

  // processor strobe forces a read; global write overrides lane controls
  always_comb begin
    if (proc_strobe)        wr_mask = '0;
    else if (!all_wr_n)     wr_mask = '1;
    else if (!lane_wr_en_n) wr_mask = ~lane_sel_n;
    else                    wr_mask = '0;
  end

endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_strobe,
  input  logic              chip_en,
  input  logic              step,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              burst_sel,
  output logic              sel_nxt,
  output burst_order_e      burst_ord
);

  localparam int HI_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  burst_order_e       ord_q, ord_d;
  logic               sel_q, sel_d;
  logic               upd_en;

  // next-state
  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    ord_d  = ord_q;
    sel_d  = sel_q;
    if (any_strobe) begin
      sel_d = chip_en;
      if (chip_en) begin
        base_d = addr_in;
        cnt_d  = '0;
        ord_d  = burst_order_e'(order_sel);
      end
    end else if (step && sel_q) begin
      cnt_d = cnt_q + {{(BURST_W-1){1'b0}}, 1'b1};
    end
  end

  assign upd_en = any_strobe | (step & sel_q);

  // registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      ord_q  <= ORDER_LINEAR;
      sel_q  <= 1'b0;
    end else if (upd_en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      ord_q  <= ord_d;
      sel_q  <= sel_d;
    end
  end

  logic [HI_W-1:0] upper;
  assign upper     = base_q[ADDR_W-1:BURST_W];
  assign cur_addr  = {upper, burst_offset(base_q[BURST_W-1:0], cnt_q, ord_q)};
  assign burst_sel = sel_q;
  assign sel_nxt   = sel_d;
  assign burst_ord = ord_q;

endmodule

// File: rtl/sram_access_stage.sv
module sram_access_stage #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_nxt,
  input  logic [LANES-1:0]        wr_mask_in,
  input  logic [LANES*LANE_W-1:0] wdata_in,
  output logic [LANES-1:0]        wr_mask_q,
  output logic [LANES*LANE_W-1:0] wdata_q,
  output logic                    rd_q
);

  localparam int WORD_W = LANES * LANE_W;

  logic [LANES-1:0]  mask_d;
  logic              rd_d;
  logic              wd_en;

  always_comb begin
    mask_d = sel_nxt ? wr_mask_in : '0;
    rd_d   = sel_nxt & (wr_mask_in == '0);
    wd_en  = |mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_mask_q <= '0;
      rd_q      <= 1'b0;
    end else begin
      wr_mask_q <= mask_d;
      rd_q      <= rd_d;
    end
  end

  // write data only captured when a write is pending
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wdata_q <= {WORD_W{1'b0}};
    else if (wd_en) wdata_q <= wdata_in;
  end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rd_word
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_mask[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = mem[addr];
  end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic                    strb_proc_n,
  input  logic                    strb_ctrl_n,
  input  logic                    adv_n,
  input  logic                    all_wr_n,
  input  logic                    lane_wr_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    ce_a_n,
  input  logic                    ce_b,
  input  logic                    ce_c_n,
  input  logic                    order_sel,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);

  localparam int WORD_W = LANES * LANE_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  logic              chip_en, any_strobe, step;
  logic [LANES-1:0]  wr_mask, wr_mask_q;
  logic [ADDR_W-1:0] cur_addr;
  logic              burst_sel, sel_nxt, rd_q;
  burst_order_e      burst_ord;
  logic [WORD_W-1:0] wdata_q, rd_word;

  sram_cmd_decode #(.LANES(LANES)) u_dec (
    .strb_proc_n  (strb_proc_n),
    .strb_ctrl_n  (strb_ctrl_n),
    .adv_n        (adv_n),
    .all_wr_n     (all_wr_n),
    .lane_wr_en_n (lane_wr_en_n),
    .lane_sel_n   (lane_sel_n),
    .ce_a_n       (ce_a_n),
    .ce_b         (ce_b),
    .ce_c_n       (ce_c_n),
    .chip_en      (chip_en),
    .any_strobe   (any_strobe),
    .step         (step),
    .wr_mask      (wr_mask)
  );

  sram_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (srst_n),
    .any_strobe (any_strobe),
    .chip_en    (chip_en),
    .step       (step),
    .addr_in    (addr_in),
    .order_sel  (order_sel),
    .cur_addr   (cur_addr),
    .burst_sel  (burst_sel),
    .sel_nxt    (sel_nxt),
    .burst_ord  (burst_ord)
  );

  sram_access_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_stage (
    .clk        (clk),
    .rst_n      (srst_n),
    .sel_nxt    (sel_nxt),
    .wr_mask_in (wr_mask),
    .wdata_in   (wdata),
    .wr_mask_q  (wr_mask_q),
    .wdata_q    (wdata_q),
    .rd_q       (rd_q)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .wr_mask (wr_mask_q),
    .addr    (cur_addr),
    .wdata   (wdata_q),
    .rd_word (rd_word)
  );

  // flow-through output, blanked when not reading
  assign rdata_oe = rd_q;
  assign rdata    = rd_q ? rd_word : {WORD_W{1'b0}};

endmodule

// File: rtl/sram_burst_chk.sv
module sram_burst_chk
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              srst_n,
  input logic              strb_proc_n,
  input logic              strb_ctrl_n,
  input logic              adv_n,
  input logic              all_wr_n,
  input logic              ce_a_n,
  input logic              ce_b,
  input logic              ce_c_n,
  input logic [WORD_W-1:0] rdata,
  input logic              rdata_oe,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              burst_sel,
  input logic              burst_ord
);

  logic en_now, strobe_now;
  assign en_now     = ~ce_a_n & ce_b & ~ce_c_n;
  assign strobe_now = ~strb_proc_n | ~strb_ctrl_n;

  AST_QUIET_DATA: assert property (@(posedge clk) disable iff (!srst_n)
    !rdata_oe |-> (rdata == '0)); // R10

  AST_DESELECT_NEXT: assert property (@(posedge clk) disable iff (!srst_n)
    (strobe_now && !en_now) |=> !rdata_oe); // R9

  AST_PROC_IS_READ: assert property (@(posedge clk) disable iff (!srst_n)
    (!strb_proc_n && en_now) |=> rdata_oe); // R6

  AST_GLOBAL_WR_NO_OE: assert property (@(posedge clk) disable iff (!srst_n)
    (strb_proc_n && !strb_ctrl_n && en_now && !all_wr_n) |=> !rdata_oe); // R7

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!srst_n)
    (!strobe_now && adv_n && burst_sel) |=> $stable(cur_addr)); // R5

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!srst_n)
    (!strobe_now && !adv_n && burst_sel && (burst_ord == ORDER_LINEAR)) |=>
      ((cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1) &&
       (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])))); // R3

endmodule

bind sync_burst_sram sram_burst_chk #(.ADDR_W(ADDR_W), .WORD_W(LANES*LANE_W)) u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .strb_proc_n (strb_proc_n),
  .strb_ctrl_n (strb_ctrl_n),
  .adv_n       (adv_n),
  .all_wr_n    (all_wr_n),
  .ce_a_n      (ce_a_n),
  .ce_b        (ce_b),
  .ce_c_n      (ce_c_n),
  .rdata       (rdata),
  .rdata_oe    (rdata_oe),
  .cur_addr    (cur_addr),
  .burst_sel   (burst_sel),
  .burst_ord   (burst_ord)
);

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int LN    = 2;
  localparam int LW    = 9;
  localparam int WW    = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in;
  logic          strb_proc_n, strb_ctrl_n, adv_n, all_wr_n, lane_wr_en_n;
  logic [LN-1:0] lane_sel_n;
  logic          ce_a_n, ce_b, ce_c_n, order_sel;
  logic [WW-1:0] wdata, rdata;
  logic          rdata_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n),
    .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .order_sel(order_sel),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  typedef struct {
    logic          sp, sc, adv, gw, bwe;
    logic [LN-1:0] bsel;
    logic          cea, ceb, cec, ord;
    logic [AW-1:0] a;
    logic [WW-1:0] d;
  } cmd_t;

  // reference model state
  logic [WW-1:0] m_mem [DEPTH];
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic          m_sel, m_ord;
  logic          exp_oe;
  logic [WW-1:0] exp_d;
  int            n_tests = 0;
  int            n_fail  = 0;

  function automatic cmd_t idle_c();
    cmd_t c;
    c.sp = 1'b1; c.sc = 1'b1; c.adv = 1'b1; c.gw = 1'b1; c.bwe = 1'b1;
    c.bsel = '1; c.cea = 1'b0; c.ceb = 1'b1; c.cec = 1'b0; c.ord = 1'b0;
    c.a = '0; c.d = '0;
    return c;
  endfunction

  task automatic drive(input cmd_t c);
    strb_proc_n = c.sp; strb_ctrl_n = c.sc; adv_n = c.adv; all_wr_n = c.gw;
    lane_wr_en_n = c.bwe; lane_sel_n = c.bsel; ce_a_n = c.cea; ce_b = c.ceb;
    ce_c_n = c.cec; order_sel = c.ord; addr_in = c.a; wdata = c.d;
  endtask

  // expected behaviour, taken from the requirements
  task automatic model(input cmd_t c);
    logic          en, strobe;
    logic [LN-1:0] mask;
    logic [1:0]    lo;
    logic [AW-1:0] ad;
    en     = !c.cea && c.ceb && !c.cec;               // R9
    strobe = !c.sp || !c.sc;
    if (strobe) begin
      m_sel = en;
      if (en) begin m_base = c.a; m_cnt = 2'd0; m_ord = c.ord; end
    end else if (!c.adv && m_sel) begin
      m_cnt = m_cnt + 2'd1;                           // R11 wrap
    end
    lo = m_ord ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);  // R3 R4
    ad = {m_base[AW-1:2], lo};
    if (!c.sp)       mask = '0;                       // R6
    else if (!c.gw)  mask = '1;                       // R7
    else if (!c.bwe) mask = ~c.bsel;                  // R8
    else             mask = '0;
    if (!m_sel) begin
      exp_oe = 1'b0; exp_d = '0;
    end else if (mask == '0) begin
      exp_oe = 1'b1; exp_d = m_mem[ad];
    end else begin
      exp_oe = 1'b0; exp_d = '0;                      // R10
      for (int i = 0; i < LN; i++)
        if (mask[i]) m_mem[ad][i*LW +: LW] = c.d[i*LW +: LW];
    end
  endtask

  task automatic check(input string tag, input string what,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic run(input cmd_t c, input string tag);
    drive(c);
    model(c);
    @(posedge clk);
    @(negedge clk);
    check(tag, "rdata_oe", WW'(rdata_oe), WW'(exp_oe));
    check(tag, "rdata", rdata, exp_d);
  endtask

  function automatic cmd_t rand_c();
    cmd_t c;
    int   r;
    c = idle_c();
    r = int'($urandom % 100);
    if (r < 20) begin
      if ($urandom % 3 == 0) c.sp = 1'b0;
      if ($urandom % 2 == 0 || c.sp) c.sc = 1'b0;
      c.a   = AW'($urandom);
      c.ord = 1'($urandom);
      if ($urandom % 8 == 0) begin
        case ($urandom % 3)
          0:       c.cea = 1'b1;
          1:       c.ceb = 1'b0;
          default: c.cec = 1'b1;
        endcase
      end
    end else if (r < 70) begin
      c.adv = 1'b0;
    end
    if ($urandom % 5 == 0) c.gw = 1'b0;
    if ($urandom % 5 < 2)  c.bwe = 1'b0;
    c.bsel = LN'($urandom);
    c.d    = WW'($urandom);
    return c;
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    cmd_t c;
    void'($urandom(32'd20240611));
    m_sel = 1'b0; m_base = '0; m_cnt = '0; m_ord = 1'b0;
    drive(idle_c());
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: quiet after reset
    run(idle_c(), "R1");
    run(idle_c(), "R1");

    // preload every word through global-write bursts (R7, R10)
    for (int b = 0; b < DEPTH/4; b++) begin
      for (int k = 0; k < 4; k++) begin
        c = idle_c(); c.gw = 1'b0; c.d = WW'($urandom);
        if (k == 0) begin c.sc = 1'b0; c.a = AW'(b*4); end
        else c.adv = 1'b0;
        run(c, "R7");
      end
    end

    // R2 R3 R11: linear burst from word 5 -> 5 6 7 4, then back to 5
    c = idle_c(); c.sc = 1'b0; c.a = AW'(5); run(c, "R2");
    c = idle_c(); c.adv = 1'b0;
    run(c, "R3"); run(c, "R3"); run(c, "R3");
    run(c, "R11");

    // R4: interleaved burst from word 10 -> 10 11 8 9
    c = idle_c(); c.sc = 1'b0; c.a = AW'(10); c.ord = 1'b1; run(c, "R4");
    c = idle_c(); c.adv = 1'b0;
    run(c, "R4"); run(c, "R4"); run(c, "R4");

    // R5: hold
    run(idle_c(), "R5");
    run(idle_c(), "R5");

    // R6: processor strobe is a read even with global write
    c = idle_c(); c.sp = 1'b0; c.gw = 1'b0; c.a = AW'(30); c.d = WW'($urandom);
    run(c, "R6");
    run(idle_c(), "R6");
    c = idle_c(); c.sp = 1'b0; c.sc = 1'b0; c.gw = 1'b0; c.a = AW'(31); c.d = WW'($urandom);
    run(c, "R6");
    run(idle_c(), "R6");

    // R8: lane writes
    c = idle_c(); c.sc = 1'b0; c.a = AW'(20); c.bwe = 1'b0; c.bsel = 2'b10;
    c.d = WW'($urandom); run(c, "R8");
    run(idle_c(), "R8");
    c = idle_c(); c.bwe = 1'b0; c.bsel = 2'b11; c.d = WW'($urandom); run(c, "R8");
    c = idle_c(); c.bsel = 2'b00; c.d = WW'($urandom); run(c, "R8");
    c = idle_c(); c.bwe = 1'b0; c.bsel = 2'b01; c.d = WW'($urandom); run(c, "R8");
    run(idle_c(), "R8");

    // R7 R10: global write overrides lane selects
    c = idle_c(); c.gw = 1'b0; c.bwe = 1'b0; c.bsel = 2'b10; c.d = WW'($urandom);
    run(c, "R10");
    run(idle_c(), "R7");

    // R9: deselect, ignored advances and writes, then recovery
    c = idle_c(); c.sc = 1'b0; c.ceb = 1'b0; c.gw = 1'b0; c.a = AW'(40); c.d = WW'($urandom);
    run(c, "R9");
    c = idle_c(); c.adv = 1'b0; c.gw = 1'b0; c.d = WW'($urandom); run(c, "R9");
    run(idle_c(), "R9");
    c = idle_c(); c.sp = 1'b0; c.cea = 1'b1; run(c, "R9");
    c = idle_c(); c.sc = 1'b0; c.cec = 1'b1; c.gw = 1'b0; c.a = AW'(41); c.d = WW'($urandom);
    run(c, "R9");
    c = idle_c(); c.sc = 1'b0; c.a = AW'(40); run(c, "R9");
    c = idle_c(); c.adv = 1'b0; run(c, "R9");

    // random traffic against the model
    for (int n = 0; n < 800; n++) run(rand_c(), "R2");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule